// File: doc/BRIEF.md
# JTAG Capture-IR Pin Probe

This block is a small, self-contained JTAG master for deciding whether a candidate set of pins carries a live test access port. A single start strobe launches a burst of test-clock pulses derived from the system clock. During the burst the block drives a fixed mode-select pattern that forces any compliant TAP controller into Test-Logic-Reset and then walks it to Shift-IR. The data input is held high throughout, and the data output line is sampled while the instruction register shifts.

A compliant TAP always loads binary `01` into the two low bits of its instruction register on Capture-IR. The first two bits that come out of Shift-IR are therefore a 1 followed by a 0. The block compares the sampled bits against this signature and reports a pass/fail verdict. It also keeps the raw samples for inspection. The controller is left in Shift-IR and never passes through Update-IR, so the probe commits no instruction on the target. Pin multiplexing across candidates is handled outside the block.

Top module: `jtag_irprobe`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `pass_o`, `tck_o`, `tms_o`, `tdi_o` and `bits_o` are all 0.
- R2: An accepted start produces exactly 18 test-clock pulses. Each pulse is high for `HALF_DIV` system clocks and low for `HALF_DIV` system clocks. `tck_o` is low whenever `busy_o` is low.
- R3: The mode-select value presented at the rising edge of pulse k (k = 0..17) is bit k of 18'h001BE. That is the sequence 0,1,1,1,1,1,0,1,1,0,0,0,0,0,0,0,0,0.
- R4: `tms_o` changes only in the system-clock cycle in which `tck_o` falls.
- R5: `tdi_o` is 1 for every cycle in which `busy_o` is 1, and 0 when idle.
- R6: Whatever state the TAP starts in, it is in Shift-IR once the burst ends. A TAP starting in Test-Logic-Reset never enters Update-IR.
- R7: `tdo_i` is sampled at the rising edges of pulses 11 to 17, which gives 7 samples. Bit 0 of `bits_o` holds the first sample and bit 6 holds the last. The samples hold until the next accepted start.
- R8: `pass_o` is 1 exactly when sample 0 is 1, sample 1 is 0, and samples 2..6 are not all equal. The verdict is valid when `done_o` pulses and holds until the next accepted start.
- R9: `done_o` is high for exactly one system-clock cycle, the cycle after the final falling test-clock edge. `busy_o` drops in that same cycle.
- R10: A start strobe that arrives while `busy_o` is 1 is ignored. The burst still has 18 pulses and a single `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch strobe, honoured only when idle |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst pulse |
| pass_o | output | 1 | Capture-IR signature found |
| bits_o | output | 7 | Sampled TDO bits, first sample in bit 0 |
| tck_o | output | 1 | Test clock to the candidate pin |
| tms_o | output | 1 | Mode select to the candidate pin |
| tdi_o | output | 1 | Test data to the candidate pin |
| tdo_i | input | 1 | Test data returned from the candidate pin |

## Verification
A bench model of the full sixteen-state TAP controller answers the probe. The model is swept over every capture value for instruction-register lengths 2 to 6. This separates a real `01` signature from capture values that fail on the first two bits. It also separates them from short registers whose tail is all ones shifted in from TDI. Starting the model in each of its sixteen states shows that the reset run reaches Shift-IR from anywhere. Stuck-low and stuck-high TDO lines must give a fail. Start strobes injected at several points of a burst must leave the pulse count and the single done pulse unchanged.

// File: rtl/irprobe_pkg.sv
package irprobe_pkg;
  // Mode-select pattern, bit k presented at test-clock pulse k.
  localparam int          PROBE_LEN    = 18;
  localparam logic [17:0] PROBE_TMS    = 18'h001BE;
  // Rising edge at which the TAP leaves Capture-IR for Shift-IR.
  localparam int          SHIFT_ENTRY  = 10;
  localparam int          FIRST_SAMPLE = SHIFT_ENTRY + 1;
  localparam int          NSAMP        = PROBE_LEN - FIRST_SAMPLE;
  localparam int          IDXW         = $clog2(PROBE_LEN);
endpackage

// File: rtl/irprobe_tck_div.sv
module irprobe_tck_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(HALF_DIV) + 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tck_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == LAST);
  assign rise_o = wrap && !tck_q;
  assign fall_o = wrap &&  tck_q;
  assign tck_o  = tck_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      tck_q <= ~tck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !tck_o || en_i);
endmodule

// File: rtl/irprobe_capture.sv
module irprobe_capture #(
  parameter int NSAMP = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             judge_i,
  input  logic             tdo_i,
  output logic [NSAMP-1:0] bits_o,
  output logic             pass_o
);
  localparam int CNTW = $clog2(NSAMP + 1);

  logic [NSAMP-1:0] sh_q;
  logic             pass_q;
  logic [CNTW-1:0]  n_q;
  logic [NSAMP-3:0] tail;
  logic             verdict;

  assign tail    = sh_q[NSAMP-1:2];
  assign verdict = sh_q[0] && !sh_q[1] && !((&tail) || !(|tail));

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      sh_q   <= '0;
      pass_q <= 1'b0;
      n_q    <= '0;
    end else begin
      if (shift_i) begin
        sh_q <= {tdo_i, sh_q[NSAMP-1:1]};
        n_q  <= n_q + 1'b1;
      end
      if (judge_i) pass_q <= verdict;
    end
  end

  assign bits_o = sh_q;
  assign pass_o = pass_q;

  // R7
  sample_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    judge_i |-> (n_q == CNTW'(NSAMP)) && !shift_i);
endmodule

// File: rtl/jtag_irprobe.sv
module jtag_irprobe
  import irprobe_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic [NSAMP-1:0] bits_o,
  output logic             tck_o,
  output logic             tms_o,
  output logic             tdi_o,
  input  logic             tdo_i
);
  localparam logic [IDXW-1:0] LAST_IDX  = IDXW'(PROBE_LEN - 1);
  localparam logic [IDXW-1:0] FIRST_IDX = IDXW'(FIRST_SAMPLE);

  logic            busy_q, done_q, tms_q, tdi_q;
  logic [IDXW-1:0] idx_q, idx_nx;
  logic            rise, fall, accept, last_fall;

  assign accept    = start_i && !busy_q;
  assign last_fall = fall && (idx_q == LAST_IDX);
  assign idx_nx    = idx_q + 1'b1;

  irprobe_tck_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en_i(busy_q),
    .tck_o(tck_o), .rise_o(rise), .fall_o(fall)
  );

  irprobe_capture #(.NSAMP(NSAMP)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear_i(accept),
    .shift_i(rise && (idx_q >= FIRST_IDX)),
    .judge_i(last_fall), .tdo_i(tdo_i),
    .bits_o(bits_o), .pass_o(pass_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tms_q  <= 1'b0;
      tdi_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        tdi_q  <= 1'b1;
        idx_q  <= '0;
        tms_q  <= PROBE_TMS[0];
      end else if (last_fall) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        tdi_q  <= 1'b0;
        tms_q  <= 1'b0;
      end else if (fall) begin
        idx_q  <= idx_nx;
        tms_q  <= PROBE_TMS[idx_nx];
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign tms_o  = tms_q;
  assign tdi_o  = tdi_q;

  // R4
  tms_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tms_o) |-> $fell(tck_o));
  // R5
  tdi_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> tdi_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o));
  // R2
  tck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !tck_o);
  // R10
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !fall) |=> $stable(idx_q));
endmodule

// File: tb/jtag_irprobe_tb.sv
module jtag_irprobe_tb;
  localparam int HALF = 2;
  localparam int NS   = 7;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic busy_o, done_o, pass_o, tck_o, tms_o, tdi_o, tdo_i;
  logic [NS-1:0] bits_o;

  int vectors = 0, miscompares = 0, cycles = 0;

  always #10 clk = ~clk;

  jtag_irprobe #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .pass_o(pass_o), .bits_o(bits_o), .tck_o(tck_o),
    .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo_i)
  );

  // TAP model
  int          tap_st = 0, ir_len = 4, stuck = 0;
  logic [7:0]  ir_cap = 8'h05, ir_sh = 8'h00;
  logic        tdo_r = 1'b0;
  int          pulses = 0, upd_ir = 0, hi_cyc = 0;
  logic [17:0] tms_seen = '0;

  assign tdo_i = (stuck == 1) ? 1'b0 : (stuck == 2) ? 1'b1 : tdo_r;

  function automatic int tap_next(input int s, input logic t);
    case (s)
      0: return t ? 0 : 1;    1: return t ? 2 : 1;
      2: return t ? 9 : 3;    3: return t ? 5 : 4;
      4: return t ? 5 : 4;    5: return t ? 8 : 6;
      6: return t ? 7 : 6;    7: return t ? 8 : 4;
      8: return t ? 2 : 1;    9: return t ? 0 : 10;
      10: return t ? 12 : 11; 11: return t ? 12 : 11;
      12: return t ? 15 : 13; 13: return t ? 14 : 13;
      14: return t ? 15 : 11; default: return t ? 2 : 1;
    endcase
  endfunction

  always @(posedge tck_o) begin
    if (pulses < 18) tms_seen[pulses] = tms_o;
    pulses = pulses + 1;
    if (tap_st == 10) ir_sh = ir_cap;
    else if (tap_st == 11)
      ir_sh = (ir_sh >> 1) | (8'(tdi_o) << (ir_len - 1));
    tap_st = tap_next(tap_st, tms_o);
    if (tap_st == 15) upd_ir = upd_ir + 1;
  end

  always @(negedge tck_o) tdo_r = (tap_st == 11) ? ir_sh[0] : 1'b0;

  // R4 monitor and R2 high-time counter
  logic prev_tms = 1'b0, prev_tck = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tms_o !== prev_tms && !(prev_tck && !tck_o)) begin
        vectors++; miscompares++;
        $display("FAIL R4 tms moved without tck fall: actual=%b expected=%b", tms_o, prev_tms);
      end
      if (tck_o) hi_cyc++;
      if (!busy_o && tck_o) begin
        vectors++; miscompares++;
        $display("FAIL R2 tck high while idle: actual=1 expected=0");
      end
    end
    prev_tms = tms_o; prev_tck = tck_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        vectors++; miscompares++;
        $display("FAIL R9 watchdog: actual=%0d expected<150000", cycles);
        summary();
      end
    end
  end

  task automatic run_probe(input int st0, input int len, input logic [7:0] cap,
                           input int stk, input int inject_at);
    logic [NS-1:0] exp_bits;
    logic [NS-3:0] tl;
    logic          exp_pass;
    int            c, done_cnt;
    tap_st = st0; ir_len = len; ir_cap = cap; stuck = stk;
    pulses = 0; upd_ir = 0; hi_cyc = 0; tms_seen = '0;
    for (int i = 0; i < NS; i++)
      exp_bits[i] = (stk == 1) ? 1'b0 : (stk == 2) ? 1'b1 :
                    (i < len) ? cap[i] : 1'b1;
    tl = exp_bits[NS-1:2];
    exp_pass = exp_bits[0] && !exp_bits[1] && !((&tl) || !(|tl));
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o === 1'b1 && tdi_o === 1'b1, "R5 tdi/busy after start", {busy_o, tdi_o}, 3);
    c = 0;
    while (done_o !== 1'b1) begin
      start_i = (c == inject_at);
      @(negedge clk);
      c++;
    end
    start_i = 1'b0;
    chk(busy_o === 1'b0, "R9 busy low with done", busy_o, 0);
    chk(bits_o === exp_bits, "R7 sampled bits", bits_o, exp_bits);
    chk(pass_o === exp_pass, "R8 verdict", pass_o, exp_pass);
    done_cnt = 1;
    for (int k = 0; k < 4 * HALF + 4; k++) begin
      @(negedge clk);
      if (done_o) done_cnt++;
    end
    chk(done_cnt == 1, "R9 R10 single done cycle", done_cnt, 1);
    chk(pulses == 18, "R2 R10 pulse count", pulses, 18);
    chk(hi_cyc == 18 * HALF, "R2 tck high time", hi_cyc, 18 * HALF);
    chk(tms_seen === 18'h001BE, "R3 tms sequence", tms_seen, 18'h001BE);
    chk(tap_st == 11, "R6 tap ends in Shift-IR", tap_st, 11);
    if (st0 == 0) chk(upd_ir == 0, "R6 no Update-IR", upd_ir, 0);
    chk(bits_o === exp_bits && pass_o === exp_pass, "R7 R8 result held", bits_o, exp_bits);
    chk(tdi_o === 1'b0 && tms_o === 1'b0, "R5 idle lines", {tdi_o, tms_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, pass_o, tck_o, tms_o, tdi_o} === 6'b0, "R1 reset outputs",
        {busy_o, done_o, pass_o, tck_o, tms_o, tdi_o}, 0);
    chk(bits_o === '0, "R1 reset bits", bits_o, 0);
    // sweep every capture value for several IR lengths
    for (int len = 2; len <= 6; len++)
      for (int cv = 0; cv < (1 << len); cv++)
        run_probe(0, len, 8'(cv), 0, -1);
    // every starting TAP state
    for (int s = 0; s < 16; s++) run_probe(s, 4, 8'h05, 0, -1);
    // stuck TDO lines
    run_probe(0, 5, 8'h15, 1, -1);
    run_probe(0, 5, 8'h15, 2, -1);
    // R10: start strobes during a burst
    for (int inj = 0; inj < 70; inj += 13) run_probe(0, 5, 8'h0D, 0, inj);
    summary();
  end
endmodule